// File: doc/BRIEF.md
# I2C Master Bus Condition Generator

This block places START, repeated START and STOP conditions on an open-drain two-wire bus. Software drives it through a five-bit command word holding enable, start, stop, hold-extend and pin-swap bits, and reads back a five-bit status code. An outside byte engine does the shifting and signals through `byte_done` that a byte has finished. The block only frames transfers: it opens the bus, re-opens it after a byte, and closes it.

Both bus lines are synchronised and watched all the time. A START seen on the wires sets an internal busy flag and a STOP clears it, so a requested START waits while another master holds the bus. Each line has an output enable that pulls it low when asserted. Otherwise the line floats high. Every setup and hold phase of a condition lasts `HALF_CYC` system clocks, where one such phase is half an SCL period.

The controller states are OFF, IDLE, WAIT_FREE, START_SETUP, START_HOLD, START_LOW, MASTER, RS_HOLD, RS_SDA_UP, RS_SCL_UP, SP_SDA_LOW, SP_SCL_UP, SP_SDA_UP and BUS_ERR. The transitions are as follows:
- With the enable bit clear, every state goes to OFF, and OFF goes to IDLE once the bit is set.
- IDLE goes to START_SETUP on a start request when the bus is free, or to WAIT_FREE when it is busy.
- WAIT_FREE goes to START_SETUP on a bus STOP, or back to IDLE if the start bit is cleared.
- START_SETUP returns to WAIT_FREE if a foreign START appears. Otherwise START_SETUP, START_HOLD and START_LOW each last one phase and lead to MASTER.
- MASTER goes to SP_SDA_LOW on a stop request. After a byte, with the start bit still set, it goes to RS_HOLD when hold-extend is on, or to RS_SDA_UP when it is off.
- RS_HOLD leads to RS_SDA_UP, then RS_SCL_UP, then START_HOLD.
- SP_SDA_LOW leads to SP_SCL_UP, then SP_SDA_UP. SP_SDA_UP waits for the STOP to appear on the wires and then goes to START_SETUP if the start bit is set, or to IDLE if it is clear.
- Any foreign condition during START_LOW through SP_SCL_UP sends the block to BUS_ERR. A stop request moves BUS_ERR to IDLE.

Top module: `i2c_cond_gen`

## Requirements
- R1: After reset, `cond_status` is 0x1F, both output enables are 0 and `cmd_q` is 0. The command word bits are [4] enable, [3] start, [2] stop, [1] hold-extend and [0] swap. Without swap, pin A carries SDA and pin B carries SCL.
- R2: While the enable bit is 0, both output enables stay 0 whatever the start and stop bits hold.
- R3: A start request on a free bus pulls SDA low while SCL is released. It then pulls SCL low and shows status 0x01 (START sent).
- R4: A start request made while a foreign START holds the bus is deferred, with the lines untouched and the status at 0x1F. The START is produced after a STOP appears on the bus.
- R5: A `byte_done` pulse in MASTER shows status 0x03. If the start bit is set, a repeated START follows with no STOP in between and shows status 0x02.
- R6: Hardware never clears the start bit. Only a write changes it.
- R7: A stop request in MASTER produces a STOP on the bus. The stop bit clears itself once that STOP is seen, the status returns to 0x1F and the lines are released.
- R8: With start and stop both set in MASTER, a STOP is sent, a START follows at once, and the status returns to 0x01.
- R9: A START or STOP on the bus that the block did not produce, arriving between START_LOW and SP_SCL_UP, gives status 0x00 and releases both lines.
- R10: A stop request in the bus-error state returns the block to IDLE (0x1F) and clears the stop bit without driving a STOP.
- R11: With hold-extend set, the SDA release that begins a repeated START comes exactly `HOLD_CYC` (8) clocks later than with the bit clear.
- R12: With swap set, SDA is driven and sensed on pin B and SCL on pin A.
- R13: A stop request outside master mode clears the stop bit and causes no bus activity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| cmd_we | input | 1 | Writes `cmd_wdata` into the command word |
| cmd_wdata | input | 5 | New command word |
| cmd_q | output | 5 | Current command word |
| byte_done | input | 1 | One-cycle pulse marking the end of a byte transfer |
| cond_status | output | 5 | Status code |
| pin_a_i | input | 1 | Level sensed on bus pin A |
| pin_b_i | input | 1 | Level sensed on bus pin B |
| pin_a_oe | output | 1 | Pulls pin A low when 1 |
| pin_b_oe | output | 1 | Pulls pin B low when 1 |

## Verification
A controller stuck in a wrong state shows up at the output enables within one clock. It can drive a line that should float, release SCL too early, or leave SDA low after a STOP. The external monitor then counts the wrong number of STARTs or STOPs.

A busy flag or bus-error path that goes wrong shows as a START that never arrives, or as a status code other than 0x00 within a few clocks of the foreign condition. A stop bit that fails to clear stays visible in `cmd_q`. The hold-extend timing is checked as an exact difference in clocks.

// File: rtl/i2c_cond_pkg.sv
`timescale 1ns/1ps
package i2c_cond_pkg;
    typedef enum logic [3:0] {
        ST_OFF, ST_IDLE, ST_WAIT_FREE, ST_START_SETUP, ST_START_HOLD, ST_START_LOW,
        ST_MASTER, ST_RS_HOLD, ST_RS_SDA_UP, ST_RS_SCL_UP, ST_SP_SDA_LOW,
        ST_SP_SCL_UP, ST_SP_SDA_UP, ST_BUS_ERR
    } cond_state_e;

    localparam logic [4:0] CODE_ERR    = 5'h00;
    localparam logic [4:0] CODE_START  = 5'h01;
    localparam logic [4:0] CODE_RSTART = 5'h02;
    localparam logic [4:0] CODE_BYTE   = 5'h03;
    localparam logic [4:0] CODE_IDLE   = 5'h1F;

    localparam int CMD_SWAP = 0;
    localparam int CMD_HOLD = 1;
    localparam int CMD_STO  = 2;
    localparam int CMD_STA  = 3;
    localparam int CMD_EN   = 4;
endpackage

// File: rtl/cond_phase_timer.sv
`timescale 1ns/1ps
module cond_phase_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         restart,
    input  logic [W-1:0] len,
    output logic         done
);
    logic [W-1:0] cnt_q;

    assign done = (cnt_q == len - W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       cnt_q <= '0;
        else if (restart) cnt_q <= '0;
        else if (!done)   cnt_q <= cnt_q + W'(1);
    end
endmodule

// File: rtl/cond_bus_watch.sv
`timescale 1ns/1ps
module cond_bus_watch #(
    parameter int SYNC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sda_i,
    input  logic scl_i,
    output logic start_det,
    output logic stop_det,
    output logic busy
);
    logic [SYNC-1:0] sda_s, scl_s;
    logic            sda_p, scl_p, busy_q;
    logic            sda_now, scl_now;

    assign sda_now   = sda_s[SYNC-1];
    assign scl_now   = scl_s[SYNC-1];
    assign start_det = scl_now & scl_p & sda_p & ~sda_now;
    assign stop_det  = scl_now & scl_p & ~sda_p & sda_now;
    assign busy      = busy_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sda_s  <= '1;
            scl_s  <= '1;
            sda_p  <= 1'b1;
            scl_p  <= 1'b1;
            busy_q <= 1'b0;
        end else begin
            sda_s <= {sda_s[SYNC-2:0], sda_i};
            scl_s <= {scl_s[SYNC-2:0], scl_i};
            sda_p <= sda_now;
            scl_p <= scl_now;
            if (start_det)     busy_q <= 1'b1;
            else if (stop_det) busy_q <= 1'b0;
        end
    end
endmodule

// File: rtl/i2c_cond_gen.sv
`timescale 1ns/1ps
module i2c_cond_gen
    import i2c_cond_pkg::*;
#(
    parameter int HALF_CYC = 10,
    parameter int HOLD_CYC = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_we,
    input  logic [4:0] cmd_wdata,
    output logic [4:0] cmd_q,
    input  logic       byte_done,
    output logic [4:0] cond_status,
    input  logic       pin_a_i,
    input  logic       pin_b_i,
    output logic       pin_a_oe,
    output logic       pin_b_oe
);
    localparam int LONGEST = (HALF_CYC > HOLD_CYC) ? HALF_CYC : HOLD_CYC;
    localparam int TW      = $clog2(LONGEST + 1) + 1;

    cond_state_e   state_q, state_d;
    logic [4:0]    cmd_r;
    logic          en_q, sta_q, sto_q, hold_q, swap_q;
    logic          sto_clr, bytes_q, rs_q;
    logic          sda_drv, scl_drv, mid_master;
    logic          sda_in, scl_in, start_det, stop_det, busy;
    logic          tm_restart, tm_done;
    logic [TW-1:0] tm_len;
    logic [4:0]    master_code;

    assign en_q   = cmd_r[CMD_EN];
    assign sta_q  = cmd_r[CMD_STA];
    assign sto_q  = cmd_r[CMD_STO];
    assign hold_q = cmd_r[CMD_HOLD];
    assign swap_q = cmd_r[CMD_SWAP];
    assign cmd_q  = cmd_r;

    // pin role exchange
    assign sda_in   = swap_q ? pin_b_i : pin_a_i;
    assign scl_in   = swap_q ? pin_a_i : pin_b_i;
    assign pin_a_oe = swap_q ? scl_drv : sda_drv;
    assign pin_b_oe = swap_q ? sda_drv : scl_drv;

    cond_bus_watch #(.SYNC(2)) watch_i (
        .clk(clk), .rst_n(rst_n), .sda_i(sda_in), .scl_i(scl_in),
        .start_det(start_det), .stop_det(stop_det), .busy(busy)
    );

    assign tm_restart = (state_d != state_q);

    cond_phase_timer #(.W(TW)) timer_i (
        .clk(clk), .rst_n(rst_n), .restart(tm_restart), .len(tm_len), .done(tm_done)
    );

    // command word: software writes win over the hardware stop clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       cmd_r <= '0;
        else if (cmd_we)  cmd_r <= cmd_wdata;
        else if (sto_clr) cmd_r[CMD_STO] <= 1'b0;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
            bytes_q <= 1'b0;
            rs_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_d == ST_START_HOLD && state_q != ST_START_HOLD) begin
                bytes_q <= 1'b0;
                rs_q    <= (state_q == ST_RS_SCL_UP);
            end else if (state_q == ST_MASTER && byte_done) begin
                bytes_q <= 1'b1;
            end
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        sto_clr = 1'b0;
        if (!en_q) begin
            state_d = ST_OFF;
        end else if (mid_master && (start_det || stop_det)) begin
            state_d = ST_BUS_ERR;
        end else begin
            unique case (state_q)
                ST_OFF: state_d = ST_IDLE;
                ST_IDLE: begin
                    if (sto_q)              sto_clr = 1'b1;
                    else if (sta_q && !busy) state_d = ST_START_SETUP;
                    else if (sta_q)         state_d = ST_WAIT_FREE;
                end
                ST_WAIT_FREE: begin
                    sto_clr = sto_q;
                    if (!sta_q)        state_d = ST_IDLE;
                    else if (stop_det) state_d = ST_START_SETUP;
                end
                ST_START_SETUP: begin
                    sto_clr = sto_q;
                    if (start_det)    state_d = ST_WAIT_FREE;
                    else if (tm_done) state_d = ST_START_HOLD;
                end
                ST_START_HOLD: if (tm_done) state_d = ST_START_LOW;
                ST_START_LOW:  if (tm_done) state_d = ST_MASTER;
                ST_MASTER: begin
                    if (sto_q)                  state_d = ST_SP_SDA_LOW;
                    else if (sta_q && bytes_q)  state_d = hold_q ? ST_RS_HOLD : ST_RS_SDA_UP;
                end
                ST_RS_HOLD:    if (tm_done) state_d = ST_RS_SDA_UP;
                ST_RS_SDA_UP:  if (tm_done) state_d = ST_RS_SCL_UP;
                ST_RS_SCL_UP:  if (tm_done) state_d = ST_START_HOLD;
                ST_SP_SDA_LOW: if (tm_done) state_d = ST_SP_SCL_UP;
                ST_SP_SCL_UP:  if (tm_done) state_d = ST_SP_SDA_UP;
                ST_SP_SDA_UP: begin
                    if (stop_det) begin
                        sto_clr = 1'b1;
                        state_d = sta_q ? ST_START_SETUP : ST_IDLE;
                    end
                end
                ST_BUS_ERR: begin
                    if (sto_q) begin
                        sto_clr = 1'b1;
                        state_d = ST_IDLE;
                    end
                end
                default: state_d = ST_OFF;
            endcase
        end
    end

    // outputs
    always_comb begin
        sda_drv     = 1'b0;
        scl_drv     = 1'b0;
        mid_master  = 1'b0;
        tm_len      = TW'(HALF_CYC);
        master_code = bytes_q ? CODE_BYTE : (rs_q ? CODE_RSTART : CODE_START);
        cond_status = CODE_IDLE;
        unique case (state_q)
            ST_START_HOLD: begin
                sda_drv = 1'b1; cond_status = master_code;
            end
            ST_START_LOW, ST_MASTER, ST_SP_SDA_LOW: begin
                sda_drv = 1'b1; scl_drv = 1'b1; mid_master = 1'b1; cond_status = master_code;
            end
            ST_RS_HOLD: begin
                sda_drv = 1'b1; scl_drv = 1'b1; mid_master = 1'b1; cond_status = master_code;
                tm_len  = TW'(HOLD_CYC);
            end
            ST_RS_SDA_UP: begin
                scl_drv = 1'b1; mid_master = 1'b1; cond_status = master_code;
            end
            ST_RS_SCL_UP: begin
                mid_master = 1'b1; cond_status = master_code;
            end
            ST_SP_SCL_UP: begin
                sda_drv = 1'b1; mid_master = 1'b1; cond_status = master_code;
            end
            ST_BUS_ERR: cond_status = CODE_ERR;
            default: ;
        endcase
    end

    // R2
    lines_free_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q |=> (!pin_a_oe && !pin_b_oe));

    // R6
    start_bit_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_we |=> (sta_q == $past(sta_q)));

    // R9
    foreign_cond_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q && mid_master && (start_det || stop_det)) |=> (state_q == ST_BUS_ERR));

    // R10
    err_recover_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BUS_ERR && en_q && sto_q && !cmd_we) |=> (state_q == ST_IDLE && !sto_q));

    // R4
    defer_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !stop_det && (state_q == ST_IDLE || state_q == ST_WAIT_FREE)) |=> !sda_drv);

    // R3
    sda_steady_scl_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!scl_drv && !$past(scl_drv) && $past(en_q) && (sda_drv != $past(sda_drv)))
        |-> (state_q == ST_START_HOLD || state_q == ST_SP_SDA_UP));
endmodule

// File: tb/i2c_cond_gen_tb_top.sv
`timescale 1ns/1ps
module i2c_cond_gen_tb_top;
    localparam int HALF = 10;
    localparam int HOLD = 8;
    localparam logic [4:0] B_EN = 5'h10, B_STA = 5'h08, B_STO = 5'h04, B_HOLD = 5'h02, B_SWAP = 5'h01;

    logic clk = 1'b0, rst_n = 1'b0;
    logic cmd_we = 1'b0, byte_done = 1'b0;
    logic [4:0] cmd_wdata = '0, cmd_q, cond_status;
    logic pin_a_oe, pin_b_oe, pin_a, pin_b;
    logic ext_sda_low = 1'b0, ext_scl_low = 1'b0, tb_swap = 1'b0;
    logic sda_phys, scl_phys, sda_prev = 1'b1, scl_prev = 1'b1;
    int   tests = 0, fails = 0, start_cnt = 0, stop_cnt = 0;

    always #2.5 clk = ~clk;

    assign pin_a    = !(pin_a_oe || (tb_swap ? ext_scl_low : ext_sda_low));
    assign pin_b    = !(pin_b_oe || (tb_swap ? ext_sda_low : ext_scl_low));
    assign sda_phys = tb_swap ? pin_b : pin_a;
    assign scl_phys = tb_swap ? pin_a : pin_b;

    i2c_cond_gen #(.HALF_CYC(HALF), .HOLD_CYC(HOLD)) dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_wdata(cmd_wdata), .cmd_q(cmd_q),
        .byte_done(byte_done), .cond_status(cond_status), .pin_a_i(pin_a), .pin_b_i(pin_b),
        .pin_a_oe(pin_a_oe), .pin_b_oe(pin_b_oe)
    );

    // bus condition counters on the physical wires
    always @(negedge clk) begin
        if (rst_n && scl_prev && scl_phys && sda_prev && !sda_phys) start_cnt <= start_cnt + 1;
        if (rst_n && scl_prev && scl_phys && !sda_prev && sda_phys) stop_cnt <= stop_cnt + 1;
        sda_prev <= sda_phys;
        scl_prev <= scl_phys;
    end

    function automatic logic [4:0] exp_code(input int phase);
        case (phase)
            0: return 5'h00;
            1: return 5'h01;
            2: return 5'h02;
            3: return 5'h03;
            default: return 5'h1F;
        endcase
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] w);
        @(negedge clk); cmd_we = 1'b1; cmd_wdata = w;
        @(negedge clk); cmd_we = 1'b0;
    endtask

    task automatic wait_code(input logic [4:0] code, input int lim, output bit hit);
        hit = 1'b0;
        for (int i = 0; i < lim; i++) begin
            @(negedge clk);
            if (cond_status == code) begin hit = 1'b1; break; end
        end
    endtask

    task automatic settle(); repeat (3 * HALF) @(negedge clk); endtask

    task automatic pulse_byte();
        @(negedge clk); byte_done = 1'b1;
        @(negedge clk); byte_done = 1'b0;
    endtask

    task automatic measure_release(output int n);
        @(negedge clk); byte_done = 1'b1;
        @(negedge clk); byte_done = 1'b0; n = 1;
        while (!sda_phys && n < 100) begin @(negedge clk); n++; end
    endtask

    task automatic stop_and_idle(input logic [4:0] base);
        bit hit;
        wr(base | B_STO);
        wait_code(exp_code(9), 200, hit);
        repeat (12) @(negedge clk);
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        bit hit;
        int s0, p0, m0, m1, r;
        r = $urandom(32'h5EED);
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 status", cond_status, exp_code(9));
        chk("R1 oe", {pin_a_oe, pin_b_oe}, 0);
        chk("R1 cmd", cmd_q, 0);

        // R2: start requested while disabled
        wr(B_STA);
        repeat (60) @(negedge clk);
        chk("R2 oe", {pin_a_oe, pin_b_oe}, 0);
        chk("R2 starts", start_cnt, 0);
        wr(5'h00);

        // R3: plain start, SDA on pin A, SCL on pin B
        wr(B_EN | B_STA);
        wait_code(exp_code(1), 200, hit);
        chk("R3 start status", hit, 1);
        chk("R3 sda low scl free", {pin_a_oe, pin_b_oe}, 2'b10);
        settle();
        chk("R3 scl held", {pin_a_oe, pin_b_oe}, 2'b11);
        chk("R3 start seen", start_cnt, 1);
        chk("R6 start bit kept", cmd_q[3], 1);

        // R5: byte then repeated start
        pulse_byte();
        wait_code(exp_code(3), 20, hit);
        chk("R5 byte status", hit, 1);
        wait_code(exp_code(2), 200, hit);
        chk("R5 rstart status", hit, 1);
        settle();
        chk("R5 second start", start_cnt, 2);
        chk("R5 no stop", stop_cnt, 0);

        // R11: hold extend
        wr(B_EN | B_STA | B_HOLD);
        measure_release(m1);
        wait_code(exp_code(2), 200, hit);
        settle();
        wr(B_EN | B_STA);
        measure_release(m0);
        wait_code(exp_code(2), 200, hit);
        settle();
        chk("R11 hold delta", m1 - m0, HOLD);

        // R7: stop
        p0 = stop_cnt;
        stop_and_idle(B_EN);
        chk("R7 status idle", cond_status, exp_code(9));
        chk("R7 stop bit cleared", cmd_q, B_EN);
        chk("R7 stop seen", stop_cnt, p0 + 1);
        chk("R7 lines free", {pin_a_oe, pin_b_oe}, 0);

        // R8: stop then start
        wr(B_EN | B_STA);
        wait_code(exp_code(1), 200, hit);
        settle();
        s0 = start_cnt; p0 = stop_cnt;
        wr(B_EN | B_STA | B_STO);
        wait_code(exp_code(9), 200, hit);
        wait_code(exp_code(1), 200, hit);
        chk("R8 restart status", hit, 1);
        settle();
        chk("R8 stop seen", stop_cnt, p0 + 1);
        chk("R8 start seen", start_cnt, s0 + 1);
        chk("R8 bits", cmd_q, B_EN | B_STA);
        stop_and_idle(B_EN);

        // R13: stop outside master mode
        p0 = stop_cnt;
        wr(B_EN | B_STO);
        repeat (20) @(negedge clk);
        chk("R13 stop bit cleared", cmd_q, B_EN);
        chk("R13 no stop", stop_cnt, p0);
        chk("R13 lines free", {pin_a_oe, pin_b_oe}, 0);

        // R4: deferred start while another master owns the bus
        ext_sda_low = 1'b1;
        repeat (10) @(negedge clk);
        wr(B_EN | B_STA);
        repeat (100) @(negedge clk);
        chk("R4 lines untouched", {pin_a_oe, pin_b_oe}, 0);
        chk("R4 status", cond_status, exp_code(9));
        ext_sda_low = 1'b0;
        wait_code(exp_code(1), 200, hit);
        chk("R4 start after stop", hit, 1);
        settle();
        stop_and_idle(B_EN);

        // R9 / R10: foreign start during repeated start setup
        wr(B_EN | B_STA);
        wait_code(exp_code(1), 200, hit);
        settle();
        pulse_byte();
        for (int i = 0; i < 200 && !scl_phys; i++) @(negedge clk);
        @(negedge clk); ext_sda_low = 1'b1;
        wait_code(exp_code(0), 50, hit);
        chk("R9 error status", hit, 1);
        @(negedge clk);
        chk("R9 lines free", {pin_a_oe, pin_b_oe}, 0);
        ext_sda_low = 1'b0;
        repeat (10) @(negedge clk);
        p0 = stop_cnt;
        wr(B_EN | B_STO);
        repeat (10) @(negedge clk);
        chk("R10 idle", cond_status, exp_code(9));
        chk("R10 stop bit cleared", cmd_q, B_EN);
        chk("R10 no stop driven", stop_cnt, p0);
        chk("R10 lines free", {pin_a_oe, pin_b_oe}, 0);

        // R12: swapped pins
        tb_swap = 1'b1;
        wr(B_EN | B_SWAP);
        s0 = start_cnt;
        wr(B_EN | B_SWAP | B_STA);
        wait_code(exp_code(1), 200, hit);
        chk("R12 start status", hit, 1);
        chk("R12 sda on pin b", {pin_a_oe, pin_b_oe}, 2'b01);
        settle();
        chk("R12 start seen", start_cnt, s0 + 1);
        stop_and_idle(B_EN | B_SWAP);
        wr(B_EN);
        tb_swap = 1'b0;

        // random sessions
        for (int it = 0; it < 12; it++) begin
            logic [4:0] base;
            bit do_rs, do_byte;
            base    = B_EN | (($urandom % 2) ? B_HOLD : 5'h0) | (($urandom % 2) ? B_SWAP : 5'h0);
            do_rs   = $urandom % 2;
            do_byte = $urandom % 2;
            tb_swap = base[0];
            wr(base);
            s0 = start_cnt; p0 = stop_cnt;
            wr(base | B_STA);
            wait_code(exp_code(1), 200, hit);
            chk("R3 random start", hit, 1);
            settle();
            if (do_rs) begin
                pulse_byte();
                wait_code(exp_code(2), 200, hit);
                chk("R5 random rstart", hit, 1);
                settle();
            end
            wr(base);
            if (do_byte) begin
                pulse_byte();
                @(negedge clk);
                chk("R5 random byte", cond_status, exp_code(3));
            end
            stop_and_idle(base);
            chk("R3 random starts", start_cnt, s0 + 1 + int'(do_rs));
            chk("R7 random stops", stop_cnt, p0 + 1);
            chk("R7 random bits", cmd_q, base);
        end
        summary();
    end
endmodule